// File: doc/BRIEF.md
# Retired Instruction Mix Monitor

This block sits beside the retire stage of a small RV32 pipeline and watches, without affecting it, what leaves the pipeline each cycle. Every cycle carries a valid flag and a 32-bit instruction word. When the valid flag is low, the slot is a bubble that the machine inserted, such as a fetch slot killed after a taken branch. While the statistics-enable bit from the control register is high, the block advances a cycle counter and a bubble counter. It also sorts each real instruction into exactly one class and advances that class's counter. The classes are the canonical no-op, arithmetic, memory access, conditional branch and everything else. A separate counter tracks loads and stores whose 12-bit address offset is non-zero.

The counters saturate at all ones and clear on reset. Software or a debug agent reads them one at a time through a 3-bit index on a combinational read port. Fractions are formed outside the block, using the cycle counter as the common denominator.

Top module: `mix_stat_mon`

## Requirements
- R1: After reset every counter reads zero.
- R2: While stats_en_i is low no counter changes, whatever the other inputs do.
- R3: The cycle counter (index 0) advances by one on every enabled cycle, bubble or not.
- R4: An enabled cycle with retire_valid_i low advances the bubble counter (index 1) and leaves every class counter and the offset counter unchanged.
- R5: The word 32'h0000_0013 counts only in the no-op counter (index 2), never as arithmetic.
- R6: Any other word with opcode bits [6:0] equal to 7'b0010011 or 7'b0110011 counts as arithmetic (index 3).
- R7: Opcodes 7'b0000011 (load) and 7'b0100011 (store) count as memory access (index 4).
- R8: Opcode 7'b1100011 counts as a conditional branch (index 5). Jumps and every remaining opcode count as miscellaneous (index 6).
- R9: Each enabled valid instruction advances exactly one of the five class counters.
- R10: The offset counter (index 7) advances for a load when bits [31:20] are non-zero, and for a store when {bits[31:25], bits[11:7]} is non-zero. Register fields outside the offset have no effect.
- R11: A counter at all ones holds that value instead of wrapping.
- R12: rd_data_o shows the counter selected by rd_idx_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stats_en_i | input | 1 | Statistics-enable bit from the control register |
| retire_valid_i | input | 1 | High for a real retired instruction, low for a bubble |
| instr_i | input | 32 | Retired instruction word |
| rd_idx_i | input | 3 | Counter select: 0 cycles, 1 bubbles, 2 no-op, 3 arithmetic, 4 memory, 5 branch, 6 misc, 7 offset |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench sweeps all 128 opcodes with offset bits in the immediate, in a register field, or absent. It interleaves bubbles and disabled cycles. One trap is a decoder that tests for arithmetic before the canonical no-op: it would count 0x13 twice, or in the wrong class. Another is an offset check that reads the load field for a store: it would count stores by their rs2 field. Bubble and disabled cycles catch a design that gates the cycle counter with valid, or lets the enable through only to some counters. A long run at the narrow counter width shows whether the counters wrap to zero instead of holding.

// File: rtl/mix_stat_pkg.sv
`timescale 1ns/1ps
package mix_stat_pkg;
  localparam int unsigned N_CLS = 5;
  localparam int unsigned N_CNT = 8;
  localparam int unsigned IDX_W = $clog2(N_CNT);

  localparam int unsigned CLS_NOP   = 0;
  localparam int unsigned CLS_ARITH = 1;
  localparam int unsigned CLS_MEM   = 2;
  localparam int unsigned CLS_BR    = 3;
  localparam int unsigned CLS_MISC  = 4;

  // read-port index map
  localparam int unsigned IDX_CYC  = 0;
  localparam int unsigned IDX_BUB  = 1;
  localparam int unsigned IDX_CLS0 = 2;
  localparam int unsigned IDX_OFF  = IDX_CLS0 + N_CLS;

  localparam logic [6:0]  OPC_LOAD   = 7'b0000011;
  localparam logic [6:0]  OPC_STORE  = 7'b0100011;
  localparam logic [6:0]  OPC_BRANCH = 7'b1100011;
  localparam logic [6:0]  OPC_OP     = 7'b0110011;
  localparam logic [6:0]  OPC_OPIMM  = 7'b0010011;
  localparam logic [31:0] NOP_WORD   = 32'h0000_0013;
endpackage

// File: rtl/mix_classifier.sv
`timescale 1ns/1ps
module mix_classifier
  import mix_stat_pkg::*;
(
  input  logic [31:0]      instr_i,
  output logic [N_CLS-1:0] cls_o,
  output logic             off_o
);
  logic [6:0]  opc;
  logic [11:0] ld_imm;
  logic [11:0] st_imm;

  always_comb begin
    opc    = instr_i[6:0];
    ld_imm = instr_i[31:20];
    st_imm = {instr_i[31:25], instr_i[11:7]};
    cls_o  = '0;
    off_o  = 1'b0;
    // no-op must win over op-imm decode
    if (instr_i == NOP_WORD) begin
      cls_o[CLS_NOP] = 1'b1;
    end else begin
      unique case (opc)
        OPC_OP, OPC_OPIMM: cls_o[CLS_ARITH] = 1'b1;
        OPC_LOAD: begin
          cls_o[CLS_MEM] = 1'b1;
          off_o          = |ld_imm;
        end
        OPC_STORE: begin
          cls_o[CLS_MEM] = 1'b1;
          off_o          = |st_imm;
        end
        OPC_BRANCH: cls_o[CLS_BR] = 1'b1;
        default:    cls_o[CLS_MISC] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mix_sat_counter.sv
`timescale 1ns/1ps
module mix_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q <= '0;
    else if (inc_i && q != '1)    q <= q + 1'b1;
  end

  assign cnt_o = q;
endmodule

// File: rtl/mix_stat_mon.sv
`timescale 1ns/1ps
module mix_stat_mon
  import mix_stat_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stats_en_i,
  input  logic             retire_valid_i,
  input  logic [31:0]      instr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [N_CLS-1:0]            cls_hit;
  logic                        off_hit;
  logic [N_CNT-1:0]            inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic                        live;

  mix_classifier u_cls (
    .instr_i (instr_i),
    .cls_o   (cls_hit),
    .off_o   (off_hit)
  );

  assign live = stats_en_i & retire_valid_i;

  always_comb begin
    inc          = '0;
    inc[IDX_CYC] = stats_en_i;
    inc[IDX_BUB] = stats_en_i & ~retire_valid_i;
    for (int k = 0; k < int'(N_CLS); k++) inc[IDX_CLS0+k] = live & cls_hit[k];
    inc[IDX_OFF] = live & off_hit;
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    mix_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .cnt_o  (cnt_q[g])
    );
  end

  assign rd_data_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/mix_stat_mon_chk.sv
`timescale 1ns/1ps
module mix_stat_mon_chk
  import mix_stat_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    stats_en_i,
  input logic                    retire_valid_i,
  input logic [N_CLS-1:0]        cls_hit,
  input logic [N_CNT-1:0][W-1:0] cnt_q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stats_en_i |=> cnt_q == $past(cnt_q));

  assert_cycle_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stats_en_i && cnt_q[IDX_CYC] != MAXV) |=> cnt_q[IDX_CYC] == W'($past(cnt_q[IDX_CYC]) + 1'b1));

  assert_bubble_no_class_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stats_en_i && !retire_valid_i) |=>
      ($stable(cnt_q[IDX_OFF:IDX_CLS0])));

  assert_one_class_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i |-> $countones(cls_hit) == 1);

  assert_off_le_mem_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[IDX_OFF] <= cnt_q[IDX_CLS0+CLS_MEM]);

  for (genvar g = 0; g < N_CNT; g++) begin : g_sat
    assert_no_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[g] == MAXV |=> cnt_q[g] == MAXV);
  end
endmodule

bind mix_stat_mon mix_stat_mon_chk #(.W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stats_en_i     (stats_en_i),
  .retire_valid_i (retire_valid_i),
  .cls_hit        (cls_hit),
  .cnt_q          (cnt_q)
);

// File: tb/mix_stat_mon_bench.sv
`timescale 1ns/1ps
module mix_stat_mon_bench;
  localparam int BW   = 8;
  localparam int MAXV = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stats_en = 1'b0;
  logic          valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [2:0]    rd_idx = '0;
  logic [BW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int exp_c[8];

  always #4 clk = ~clk;

  mix_stat_mon #(.CNT_W(BW)) u_mix_stat_mon (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .stats_en_i     (stats_en),
    .retire_valid_i (valid),
    .instr_i        (instr),
    .rd_idx_i       (rd_idx),
    .rd_data_o      (rd_data)
  );

  // class index per R5..R8: 0 nop, 1 arith, 2 mem, 3 branch, 4 misc
  function automatic int cls_of(logic [31:0] w);
    if (w == 32'h0000_0013) return 0;
    case (w[6:0])
      7'b0010011, 7'b0110011: return 1;
      7'b0000011, 7'b0100011: return 2;
      7'b1100011:             return 3;
      default:                return 4;
    endcase
  endfunction

  function automatic bit off_of(logic [31:0] w);
    if (w[6:0] == 7'b0000011) return |w[31:20];
    if (w[6:0] == 7'b0100011) return |{w[31:25], w[11:7]};
    return 1'b0;
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic bump(int i);
    if (exp_c[i] < MAXV) exp_c[i]++;
  endtask

  // called just after a negedge; read port is combinational (R12)
  task automatic check_all(string ctx);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.2;
      n_chk++;
      if (int'(rd_data) != exp_c[i]) begin
        n_bad++;
        $display("FAIL %s/%s/R12 idx %0d instr %h got %0d expected %0d",
                 ctx, tag_of(i), i, instr, rd_data, exp_c[i]);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; stats_en = 1'b0; valid = 1'b0; instr = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) exp_c[i] = 0;
    check_all("R1");
  endtask

  task automatic apply(bit en, bit v, logic [31:0] w, string ctx);
    stats_en = en; valid = v; instr = w;
    if (en) begin
      bump(0);
      if (!v) bump(1);
      else begin
        bump(2 + cls_of(w));
        if (off_of(w)) bump(7);
      end
    end
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired R1 got hang expected completion");
    finish_run();
  end

  initial begin
    for (int o = 0; o < 128; o++) begin
      logic [31:0] base;
      base = {25'b0, 7'(o)};
      do_reset();
      apply(1'b1, 1'b1, base,              "R9");
      apply(1'b1, 1'b1, base | (32'd1 << 20), "R9");
      apply(1'b1, 1'b1, base | (32'd1 << 7),  "R9");
      apply(1'b1, 1'b1, base | (32'd1 << 31), "R9");
      apply(1'b1, 1'b0, base | (32'd1 << 31), "R4");
      apply(1'b0, 1'b1, base | (32'd1 << 20), "R2");
      apply(1'b0, 1'b0, base,              "R2");
      apply(1'b1, 1'b1, base | 32'h0000_0F80, "R10");
    end
    // jumps land in misc
    do_reset();
    apply(1'b1, 1'b1, 32'h0040_006F, "R8");
    apply(1'b1, 1'b1, 32'h0000_8067, "R8");
    // saturation at the narrow width
    do_reset();
    for (int n = 0; n < 300; n++) apply(1'b1, 1'b1, 32'h0010_2083, "R11");
    for (int n = 0; n < 4; n++)   apply(1'b1, 1'b0, 32'h0, "R11");
    finish_run();
  end
endmodule